// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Tap Engine

This block runs one multiply-accumulate tap operation again and again under a repeat counter, the inner loop of a FIR filter or a correlation. One start strobe carries an 8-bit repeat constant, a 2-bit operation code, two data pointers, a coefficient address and the bounds of a ring buffer in data memory. The engine then walks the buffers itself. Each tap multiplies two signed 16-bit words and adds the product into a 48-bit accumulator.

The first operand always comes from the data memory through the primary pointer. Bit 0 of the operation code selects the second operand. When it is 0 the operand comes from coefficient memory. When it is 1 it comes from a second data buffer through the secondary pointer. Bit 1 of the code selects the correlation form, which uses 48-bit accumulation and 3 cycles per tap. When bit 1 is 0 the engine uses 32-bit accumulation and 2 cycles per tap.

The memory ports are plain synchronous reads with a fixed latency of one cycle and no back-pressure. Interrupt requests that arrive while the sequence runs are held back and released with the done pulse.

Top module: `tap_engine`

## Requirements
- R1: An accepted start with repeat constant K runs exactly K+2 taps. `busy` is high for (K+2) times the cycles per tap, starting in the cycle after the start edge.
- R2: Code 00 multiplies the data word at the primary pointer by the coefficient word. It accumulates in 32 bits and takes 2 cycles per tap.
- R3: Code 01 multiplies the data word at the primary pointer by the data word at the secondary pointer. It accumulates in 32 bits and takes 2 cycles per tap.
- R4: Codes 10 and 11 are the correlation forms, with the same operand sources as 00 and 01. They accumulate in 48 bits and take 3 cycles per tap.
- R5: After each tap the primary byte pointer advances by 2. The secondary pointer advances by 2 only when code bit 0 is 1. The coefficient word address advances by 1 only when code bit 0 is 0, and it never wraps.
- R6: A data pointer whose advanced value reaches ring_base + ring_len or more becomes ring_base instead.
- R7: The accumulator is cleared on an accepted start. In the 32-bit codes the sum wraps modulo 2^32, and bits 47:32 repeat bit 31.
- R8: An `irq_in` pulse seen while `busy` is high keeps `irq_out` low until `busy` falls. `irq_out` is then high in the done cycle. When the engine is not busy, `irq_out` follows `irq_in`.
- R9: `done` is high for exactly one cycle, the cycle after the last tap's final cycle. `acc_out` holds its value from then until the next accepted start.
- R10: A start is accepted only when the engine is idle, meaning `busy` and `done` are both low. A start at any other time changes neither the result nor the timing.
- R11: Reads go out in the first cycle of each tap, with `dat_rd` (and `coef_rd` when code bit 0 is 0) high for one cycle. Read data is expected on the `_q` inputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; ignored unless idle |
| rpt_cnt | input | 8 | Repeat constant K (taps = K+2) |
| op_sel | input | 2 | Operation code |
| ptr0_init | input | AW | Primary data byte pointer at start |
| ptr1_init | input | AW | Secondary data byte pointer at start |
| coef_init | input | CW | First coefficient word address |
| ring_base | input | AW | Ring buffer base, bytes |
| ring_len | input | AW | Ring buffer length, bytes |
| dat_rd | output | 1 | Data read strobe |
| dat0_addr | output | AW | Primary data byte address |
| dat1_addr | output | AW | Secondary data byte address |
| dat0_q | input | 16 | Primary read data, one cycle after strobe |
| dat1_q | input | 16 | Secondary read data, one cycle after strobe |
| coef_rd | output | 1 | Coefficient read strobe |
| coef_addr | output | CW | Coefficient word address |
| coef_q | input | 16 | Coefficient read data, one cycle after strobe |
| acc_out | output | 48 | Accumulator |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| irq_in | input | 1 | Interrupt request in |
| irq_out | output | 1 | Interrupt request released to the core |

## Verification
The pointer assertions assume that both start pointers lie inside the ring, that the pointers are even, and that the ring length is at least 2 bytes and even. Every scenario loads pointers that meet these conditions. The assertions also assume that the memories answer in exactly one cycle. The bench's memory model returns data from the addresses of the previous cycle's strobe, so this holds. Stray starts and interrupt pulses are applied only in the middle of a running sequence, so the properties that cover them see the engine busy.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } tap_state_e;

  localparam int unsigned OPW = 16;
  localparam int unsigned PRW = 2 * OPW;
  localparam int unsigned ACW = 48;

  function automatic logic wide_mode(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic dual_buf(input logic [1:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/tap_seq.sv
module tap_seq
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] rpt,
  input  logic [1:0] code,
  output logic       load,
  output logic       busy,
  output logic       done,
  output logic       rd_fire,
  output logic       cap,
  output logic       step,
  output logic [1:0] code_q
);
  localparam int unsigned TW = 9;

  tap_state_e      st;
  logic [TW-1:0]   left;
  logic [1:0]      ph;
  logic [1:0]      last_ph;

  assign last_ph = wide_mode(code_q) ? 2'd2 : 2'd1;
  assign load    = start && (st == ST_IDLE);
  assign busy    = (st == ST_RUN);
  assign done    = (st == ST_FIN);
  assign rd_fire = busy && (ph == 2'd0);
  assign cap     = busy && (ph == 2'd1);
  assign step    = busy && (ph == last_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      left   <= '0;
      ph     <= '0;
      code_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          code_q <= code;
          left   <= {1'b0, rpt} + TW'(2);
          ph     <= '0;
          st     <= ST_RUN;
        end
        ST_RUN: begin
          if (ph == last_ph) begin
            ph   <= '0;
            left <= left - TW'(1);
            if (left == TW'(1)) st <= ST_FIN;
          end else begin
            ph <= ph + 2'd1;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) && start |=> code_q == $past(code_q));
  p_read_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_fire);
endmodule

// File: rtl/tap_ptr.sv
module tap_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] ptr
);
  logic [AW:0] ring_end;
  logic [AW:0] nxt;

  assign ring_end = {1'b0, base} + {1'b0, len};
  assign nxt      = {1'b0, ptr} + (AW+1)'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= init;
    else if (adv)    ptr <= (nxt >= ring_end) ? base : nxt[AW-1:0];
  end

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load |=> (ptr == $past(ptr) + AW'(2)) || (ptr == $past(base)));
  p_ptr_in_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && (len >= AW'(2)) |=> ({1'b0, ptr} < $past(ring_end)));
endmodule

// File: rtl/tap_mac.sv
module tap_mac
  import tap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cap,
  input  logic                  add,
  input  logic                  wide,
  input  logic signed [OPW-1:0] opa,
  input  logic signed [OPW-1:0] opb,
  output logic [ACW-1:0]        acc
);
  logic signed [PRW-1:0] prod_now;
  logic signed [PRW-1:0] prod_q;
  logic signed [PRW-1:0] prod_use;
  logic [PRW-1:0]        sum_n;
  logic [ACW-1:0]        sum_w;

  assign prod_now = opa * opb;
  assign prod_use = wide ? prod_q : prod_now;
  assign sum_n    = acc[PRW-1:0] + prod_use;
  assign sum_w    = acc + {{(ACW-PRW){prod_use[PRW-1]}}, prod_use};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      acc    <= '0;
    end else begin
      if (cap) prod_q <= prod_now;
      if (clr)      acc <= '0;
      else if (add) acc <= wide ? sum_w : {{(ACW-PRW){sum_n[PRW-1]}}, sum_n};
    end
  end

  p_narrow_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wide && $past(add) && !$past(clr) |-> acc[ACW-1:PRW] == {(ACW-PRW){acc[PRW-1]}});
endmodule

// File: rtl/tap_engine.sv
module tap_engine
  import tap_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    rpt_cnt,
  input  logic [1:0]    op_sel,
  input  logic [AW-1:0] ptr0_init,
  input  logic [AW-1:0] ptr1_init,
  input  logic [CW-1:0] coef_init,
  input  logic [AW-1:0] ring_base,
  input  logic [AW-1:0] ring_len,
  output logic          dat_rd,
  output logic [AW-1:0] dat0_addr,
  output logic [AW-1:0] dat1_addr,
  input  logic [15:0]   dat0_q,
  input  logic [15:0]   dat1_q,
  output logic          coef_rd,
  output logic [CW-1:0] coef_addr,
  input  logic [15:0]   coef_q,
  output logic [47:0]   acc_out,
  output logic          busy,
  output logic          done,
  input  logic          irq_in,
  output logic          irq_out
);
  localparam int unsigned NPTR = 2;

  logic          load, rd_fire, cap, step;
  logic [1:0]    code_q;
  logic [AW-1:0] base_q, len_q;
  logic          irq_held;
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_val  [NPTR];
  logic [NPTR-1:0] ptr_adv;

  tap_seq u_seq (
    .clk, .rst_n, .start, .rpt(rpt_cnt), .code(op_sel),
    .load, .busy, .done, .rd_fire, .cap, .step, .code_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      len_q     <= '0;
      coef_addr <= '0;
    end else if (load) begin
      base_q    <= ring_base;
      len_q     <= ring_len;
      coef_addr <= coef_init;
    end else if (step && !dual_buf(code_q)) begin
      coef_addr <= coef_addr + CW'(1);
    end
  end

  assign ptr_init[0] = ptr0_init;
  assign ptr_init[1] = ptr1_init;
  assign ptr_adv[0]  = step;
  assign ptr_adv[1]  = step && dual_buf(code_q);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    tap_ptr #(.AW(AW)) u_ptr (
      .clk, .rst_n, .load, .init(ptr_init[g]), .adv(ptr_adv[g]),
      .base(base_q), .len(len_q), .ptr(ptr_val[g])
    );
  end

  assign dat0_addr = ptr_val[0];
  assign dat1_addr = ptr_val[1];
  assign dat_rd    = rd_fire;
  assign coef_rd   = rd_fire && !dual_buf(code_q);

  tap_mac u_mac (
    .clk, .rst_n, .clr(load), .cap, .add(step), .wide(wide_mode(code_q)),
    .opa(dat0_q), .opb(dual_buf(code_q) ? dat1_q : coef_q), .acc(acc_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              irq_held <= 1'b0;
    else if (busy && irq_in) irq_held <= 1'b1;
    else if (!busy)          irq_held <= 1'b0;
  end
  assign irq_out = !busy && (irq_in || irq_held);

  p_irq_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && irq_in |=> busy || irq_out);
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(acc_out));
  p_coef_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dual_buf(code_q) |=> $stable(coef_addr));
endmodule

// File: tb/tb_tap_engine.sv
module tb_tap_engine;
  localparam int AW = 16;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] rpt_cnt = '0;
  logic [1:0] op_sel = '0;
  logic [AW-1:0] ptr0_init = '0, ptr1_init = '0, ring_base = '0, ring_len = '0;
  logic [CW-1:0] coef_init = '0;
  logic dat_rd, coef_rd, busy, done, irq_out;
  logic irq_in = 1'b0;
  logic [AW-1:0] dat0_addr, dat1_addr;
  logic [CW-1:0] coef_addr;
  logic [15:0] dat0_q, dat1_q, coef_q;
  logic [47:0] acc_out;
  logic big = 1'b0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  tap_engine #(.AW(AW), .CW(CW)) dut (
    .clk, .rst_n, .start, .rpt_cnt, .op_sel, .ptr0_init, .ptr1_init, .coef_init,
    .ring_base, .ring_len, .dat_rd, .dat0_addr, .dat1_addr, .dat0_q, .dat1_q,
    .coef_rd, .coef_addr, .coef_q, .acc_out, .busy, .done, .irq_in, .irq_out
  );

  function automatic logic [15:0] dat_fn(input logic [AW-1:0] a);
    return big ? 16'h8000 : 16'(a * 16'd97 + 16'h9234);
  endfunction
  function automatic logic [15:0] coef_fn(input logic [CW-1:0] a);
    return big ? 16'h8000 : (16'(a) * 16'd211) ^ 16'h7e01;
  endfunction

  always @(posedge clk) begin
    if (dat_rd) begin
      dat0_q <= dat_fn(dat0_addr);
      dat1_q <= dat_fn(dat1_addr);
    end
    if (coef_rd) coef_q <= coef_fn(coef_addr);
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                         input logic [AW-1:0] l);
    int n = int'(p) + 2;
    return (n >= int'(b) + int'(l)) ? b : AW'(n);
  endfunction

  task automatic run(input string req, input logic [1:0] op, input logic [7:0] k,
                     input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                     input logic [AW-1:0] b, input logic [AW-1:0] l,
                     input logic [CW-1:0] c0, input bit poke, input bit irq);
    int taps = int'(k) + 2;
    int cpt = op[1] ? 3 : 2;
    int cyc = 0, addr_bad = 0, irq_early = 0;
    logic [AW-1:0] ea = p0, eb = p1;
    logic [CW-1:0] ec = c0;
    logic [47:0] exp_acc = '0;
    logic [31:0] n32 = '0;
    logic [47:0] hold;
    for (int t = 0; t < taps; t++) begin
      logic signed [31:0] pr;
      logic [15:0] sb;
      sb = op[0] ? dat_fn(eb) : coef_fn(ec);
      pr = $signed(dat_fn(ea)) * $signed(sb);
      if (op[1]) exp_acc = exp_acc + {{16{pr[31]}}, pr};
      else begin n32 = n32 + pr; exp_acc = {{16{n32[31]}}, n32}; end
      ea = wrap(ea, b, l);
      if (op[0]) eb = wrap(eb, b, l); else ec = ec + CW'(1);
    end
    ea = p0; eb = p1; ec = c0;
    @(negedge clk);
    op_sel = op; rpt_cnt = k; ptr0_init = p0; ptr1_init = p1;
    ring_base = b; ring_len = l; coef_init = c0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_sel = ~op; rpt_cnt = 8'd0;
    while (!done && cyc < 2000) begin
      if (busy) cyc++;
      if (dat_rd) begin
        if (dat0_addr !== ea || (op[0] && dat1_addr !== eb) ||
            (!op[0] && (coef_addr !== ec || !coef_rd))) addr_bad++;
        if (op[0] && coef_rd) addr_bad++;
        ea = wrap(ea, b, l);
        if (op[0]) eb = wrap(eb, b, l); else ec = ec + CW'(1);
      end
      if (busy && irq_out) irq_early++;
      start = poke && cyc == 3;
      irq_in = irq && cyc == 4;
      @(negedge clk);
    end
    start = 1'b0; irq_in = 1'b0;
    check({req, " R1 busy cycles"}, 64'(cyc), 64'(taps * cpt));
    check({req, " R11/R5/R6 read addresses"}, 64'(addr_bad), 64'd0);
    check({req, " R2/R3/R4/R7 acc"}, 64'(acc_out), 64'(exp_acc));
    if (irq) begin
      check({req, " R8 irq held while busy"}, 64'(irq_early), 64'd0);
      check({req, " R8 irq released at done"}, 64'(irq_out), 64'd1);
    end
    hold = acc_out;
    @(negedge clk);
    check({req, " R9 done single cycle"}, 64'(done), 64'd0);
    check({req, " R9 acc held"}, 64'(acc_out), 64'(hold));
  endtask

  task automatic t_reset();
    check("R9 reset done", 64'(done), 64'd0);
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R7 reset acc", 64'(acc_out), 64'd0);
    check("R8 reset irq", 64'(irq_out), 64'd0);
    irq_in = 1'b1;
    #1;
    check("R8 idle irq passes", 64'(irq_out), 64'd1);
    irq_in = 1'b0;
  endtask

  task automatic t_fir_coef();  run("R2 code00", 2'b00, 8'd3, 16'h10, 16'h0, 16'h10, 16'h20, 12'h5, 0, 0); endtask
  task automatic t_fir_dual();  run("R3 code01 wrap", 2'b01, 8'd6, 16'h1c, 16'h12, 16'h10, 16'h10, 12'h0, 0, 0); endtask
  task automatic t_cor_coef();  run("R4 code10", 2'b10, 8'd2, 16'h40, 16'h0, 16'h40, 16'h08, 12'h20, 0, 0); endtask
  task automatic t_cor_dual();  run("R4 code11", 2'b11, 8'd4, 16'h22, 16'h2e, 16'h20, 16'h10, 12'h0, 0, 0); endtask
  task automatic t_min_rpt();   run("R1 K=0", 2'b00, 8'd0, 16'h6, 16'h0, 16'h0, 16'h40, 12'h0, 0, 0); endtask
  task automatic t_max_rpt();   run("R1 K=255", 2'b01, 8'd255, 16'h0, 16'h80, 16'h0, 16'h100, 12'h0, 0, 0); endtask
  task automatic t_wrap32();
    big = 1'b1;
    run("R7 32-bit wrap", 2'b00, 8'd1, 16'h0, 16'h0, 16'h0, 16'h20, 12'h0, 0, 0);
    run("R4 48-bit no wrap", 2'b10, 8'd1, 16'h0, 16'h0, 16'h0, 16'h20, 12'h0, 0, 0);
    big = 1'b0;
  endtask
  task automatic t_busy_start(); run("R10 start while busy", 2'b10, 8'd5, 16'h30, 16'h0, 16'h30, 16'h0a, 12'h9, 1, 0); endtask
  task automatic t_irq();        run("R8 irq queued", 2'b01, 8'd3, 16'h8, 16'h4, 16'h0, 16'h10, 12'h0, 0, 1); endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fir_coef();
    t_fir_dual();
    t_cor_coef();
    t_cor_dual();
    t_min_rpt();
    t_max_rpt();
    t_wrap32();
    t_busy_start();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule